// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers six interrupt flags and presents one vectored request to a processor core. The six flags are: two external pins, three timer overflows and one serial-port request. A core-side handshake completes each request. The core acknowledges the request it is shown, and later pulses a return-from-interrupt when the service routine ends. The block runs its own machine-cycle state sequencer and publishes the current state index, so that peripherals can align their flag updates to it.

Flags are captured only once per machine cycle, at a fixed state. As a result, when a flag is raised inside the cycle decides whether it is seen in that cycle or in the next one. The core can write an enable register and a priority register. The enable register has one bit per source, a reserved bit that always reads as zero, and a global enable bit. The priority register puts each source at one of two levels. The block tracks which levels are in service, so a high-level request can interrupt a low-level routine but not the reverse. On acknowledge, it sends a one-cycle clear pulse back to the peripherals whose flags the hardware clears.

Top module: `ivc_core`

## Requirements
- R1: Source indices are fixed: 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial, 5 = timer 2. When `irq_o` is high, `vec_o` carries the index of the chosen source.
- R2: Enable bits 0 to 5 gate their own source. A source whose bit is 0 is never requested, even while its flag is captured. Setting the bit later lets the captured flag through.
- R3: While enable bit 7 (global) is 0, `irq_o` stays low whatever flags and per-source bits are set.
- R4: Enable bit 6 is reserved. Writing 1 to it has no effect, and `en_rd_o[6]` always reads 0.
- R5: The machine cycle has six states, indexed 0 to 5 on `mstate_o`. Flags are captured on the clock edge that ends state 1. A flag raised during state 1 is requested from state 2 of the same cycle. A flag raised during state 4 is not requested until state 2 of the next cycle.
- R6: Among pending requests of one level, the lowest source index wins.
- R7: A pending source whose priority bit is 1 (high level) wins over any pending low-level source. `lvl_o` shows the level of the request.
- R8: A high-level request is raised while only a low-level service is active. No request is raised while a high-level service is active, and no low-level request is raised while a low-level service is active.
- R9: A `reti_i` pulse ends the most recent service: the high level if it is active, otherwise the low level.
- R10: An `ack_i` while `irq_o` is high starts service at the request's level, and `irq_o` drops on the next cycle. On the cycle after the acknowledge, `clr_o` pulses for exactly one cycle with the bit of the acknowledged source, for sources 0 to 3 only. For sources 4 and 5, `clr_o` stays 0.
- R11: After reset: enable and priority registers are 0, no service is active, `irq_o` and `clr_o` are low, and `mstate_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine-cycle state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_i | input | 6 | Raw flags from the sources, indexed as in R1 |
| en_we_i | input | 1 | Write strobe for the enable register |
| pri_we_i | input | 1 | Write strobe for the priority register |
| wdata_i | input | 8 | Write data (priority uses bits 5:0) |
| ack_i | input | 1 | Core acknowledge of the current request |
| reti_i | input | 1 | Core return-from-interrupt pulse |
| irq_o | output | 1 | Request to the core |
| vec_o | output | 3 | Index of the requested source |
| lvl_o | output | 1 | Level of the request, 1 = high |
| clr_o | output | 6 | One-cycle flag clear pulses to the sources |
| en_rd_o | output | 8 | Enable register read value |
| pri_rd_o | output | 6 | Priority register read value |
| mstate_o | output | 3 | Current machine-cycle state index |

## Verification
Most faults in this block reach the ports quickly. If the service-level state is corrupted, the request is either held back or raised during a service it should not interrupt. The next flag capture exposes this, at most six cycles later. If the capture register is wrong, a flag shows up in the wrong machine cycle, or a cleared source is requested again after its acknowledge. A wrong clear mask shows up one cycle after the acknowledge, as a missing or extra pulse on `clr_o`.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    localparam int IVC_NSRC = 6;

    typedef enum logic [2:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4,
        SRC_TMR2 = 3'd5
    } ivc_src_e;

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } ivc_lvl_e;
endpackage

// File: rtl/ivc_seq.sv
module ivc_seq #(
    parameter int STATES  = 6,
    parameter int SAMP_ST = 1,
    localparam int SW     = $clog2(STATES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [SW-1:0] state_o,
    output logic          cap_o
);
    logic [SW-1:0] st_d, st_q;

    always_comb begin
        st_d = (st_q == SW'(STATES - 1)) ? '0 : st_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign state_o = st_q;
    assign cap_o   = (st_q == SW'(SAMP_ST));

    // R5: the sequencer wraps only from the last state
    a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SW'(STATES - 1)) |=> (st_q == '0));
endmodule

// File: rtl/ivc_pick.sv
module ivc_pick #(
    parameter int N  = 6,
    localparam int VW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    output logic          valid_o,
    output logic [VW-1:0] idx_o
);
    always_comb begin
        valid_o = |req_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = VW'(i);
        end
    end
endmodule

// File: rtl/ivc_core.sv
module ivc_core
    import ivc_pkg::*;
#(
    parameter int          N_SRC    = IVC_NSRC,
    parameter int          STATES   = 6,
    parameter int          SAMP_ST  = 1,
    parameter logic [N_SRC-1:0] CLR_MASK = 6'b001111,
    localparam int         VW       = $clog2(N_SRC),
    localparam int         SW       = $clog2(STATES),
    localparam int         RW       = N_SRC + 2,
    localparam int         RSV_BIT  = N_SRC,
    localparam int         GEN_BIT  = N_SRC + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] flag_i,
    input  logic             en_we_i,
    input  logic             pri_we_i,
    input  logic [RW-1:0]    wdata_i,
    input  logic             ack_i,
    input  logic             reti_i,
    output logic             irq_o,
    output logic [VW-1:0]    vec_o,
    output logic             lvl_o,
    output logic [N_SRC-1:0] clr_o,
    output logic [RW-1:0]    en_rd_o,
    output logic [N_SRC-1:0] pri_rd_o,
    output logic [SW-1:0]    mstate_o
);
    typedef struct packed {
        logic [RW-1:0]    en;
        logic [N_SRC-1:0] pri;
        logic [N_SRC-1:0] snap;
        logic [1:0]       act;   // [1] high in service, [0] low in service
        logic [N_SRC-1:0] clr;
    } regs_t;

    localparam logic [RW-1:0] EN_WMASK = ~(RW'(1) << RSV_BIT);

    regs_t r_d, r_q;
    logic  cap;
    logic [N_SRC-1:0] live, hi_req, lo_req;
    logic  hi_v, lo_v;
    logic [VW-1:0] hi_idx, lo_idx;
    logic [N_SRC-1:0] ack_sel;
    logic  take;

    ivc_seq #(.STATES(STATES), .SAMP_ST(SAMP_ST)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_o (mstate_o),
        .cap_o   (cap)
    );

    assign live   = r_q.snap & r_q.en[N_SRC-1:0] & {N_SRC{r_q.en[GEN_BIT]}};
    assign hi_req = live & r_q.pri & {N_SRC{~r_q.act[1]}};
    assign lo_req = live & ~r_q.pri & {N_SRC{r_q.act == 2'b00}};

    ivc_pick #(.N(N_SRC)) u_pick_hi (.req_i(hi_req), .valid_o(hi_v), .idx_o(hi_idx));
    ivc_pick #(.N(N_SRC)) u_pick_lo (.req_i(lo_req), .valid_o(lo_v), .idx_o(lo_idx));

    assign irq_o   = hi_v | lo_v;
    assign lvl_o   = hi_v;
    assign vec_o   = hi_v ? hi_idx : lo_idx;
    assign take    = ack_i & irq_o;
    assign ack_sel = N_SRC'(1) << vec_o;

    always_comb begin
        r_d     = r_q;
        r_d.clr = '0;
        if (en_we_i)  r_d.en  = wdata_i & EN_WMASK;
        if (pri_we_i) r_d.pri = wdata_i[N_SRC-1:0];
        if (cap)      r_d.snap = flag_i;
        if (reti_i) begin
            if (r_q.act[1]) r_d.act[1] = 1'b0;
            else            r_d.act[0] = 1'b0;
        end
        if (take) begin
            r_d.snap = r_d.snap & ~ack_sel;
            r_d.clr  = ack_sel & CLR_MASK;
            if (lvl_o) r_d.act[1] = 1'b1;
            else       r_d.act[0] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign clr_o    = r_q.clr;
    assign en_rd_o  = r_q.en;
    assign pri_rd_o = r_q.pri;

    a_r4_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.en[RSV_BIT] == 1'b0);

    a_r3_global_off: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.en[GEN_BIT] |-> !irq_o);

    a_r8_high_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.act[1] |-> !irq_o);

    a_r8_low_only_high: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.act[0] && irq_o) |-> lvl_o);

    a_r10_clear_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (vec_o < VW'(4))) |=> (clr_o == (N_SRC'(1) << $past(vec_o))));

    a_r10_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (vec_o >= VW'(4))) |=> (clr_o == '0));

    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_o));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap && !take) |=> $stable(r_q.snap));
endmodule

// File: tb/ivc_core_tb.sv
`timescale 1ns/1ps
module ivc_core_tb;
    import ivc_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] flag_i = '0;
    logic       en_we_i = 1'b0, pri_we_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic       ack_i = 1'b0, reti_i = 1'b0;
    logic       irq_o, lvl_o;
    logic [2:0] vec_o, mstate_o;
    logic [5:0] clr_o, pri_rd_o;
    logic [7:0] en_rd_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ivc_core u_dut (
        .clk(clk), .rst_n(rst_n), .flag_i(flag_i), .en_we_i(en_we_i),
        .pri_we_i(pri_we_i), .wdata_i(wdata_i), .ack_i(ack_i), .reti_i(reti_i),
        .irq_o(irq_o), .vec_o(vec_o), .lvl_o(lvl_o), .clr_o(clr_o),
        .en_rd_o(en_rd_o), .pri_rd_o(pri_rd_o), .mstate_o(mstate_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_en(input logic [7:0] v);
        en_we_i = 1'b1; wdata_i = v; step(); en_we_i = 1'b0;
    endtask

    task automatic wr_pri(input logic [5:0] v);
        pri_we_i = 1'b1; wdata_i = {2'b00, v}; step(); pri_we_i = 1'b0;
    endtask

    task automatic wait_cap();
        do step(); while (mstate_o != 3'd2);
    endtask

    task automatic wait_state(input logic [2:0] s);
        do step(); while (mstate_o != s);
    endtask

    task automatic do_ack();
        ack_i = 1'b1; step(); ack_i = 1'b0;
    endtask

    task automatic do_reti();
        reti_i = 1'b1; step(); reti_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 irq", irq_o, 0);
        chk("R11 en", en_rd_o, 0);
        chk("R11 pri", pri_rd_o, 0);
        chk("R11 clr", clr_o, 0);
        chk("R11 state", mstate_o, 0);
    endtask

    task automatic t_reserved();
        wr_en(8'hFF);
        chk("R4 reserved bit reads zero", en_rd_o, 8'hBF);
    endtask

    task automatic t_order();
        flag_i = 6'h3F;
        wait_cap();
        for (int i = 0; i < 6; i++) begin
            chk("R6 irq", irq_o, 1);
            chk("R1 R6 order", vec_o, i);
            do_ack();
            chk("R10 clr", clr_o, (i < 4) ? (1 << i) : 0);
            chk("R10 irq drops", irq_o, 0);
            flag_i[i] = 1'b0;
            do_reti();
            chk("R10 single pulse", clr_o, 0);
        end
    endtask

    task automatic t_enable();
        wr_en(8'hBB);
        flag_i = 6'b000100;
        wait_cap();
        chk("R2 masked", irq_o, 0);
        wr_en(8'hBF);
        chk("R2 unmasked irq", irq_o, 1);
        chk("R2 unmasked vec", vec_o, SRC_EXT1);
        wr_en(8'h3F);
        chk("R3 global off", irq_o, 0);
        flag_i = '0;
        wait_cap();
        wr_en(8'hBF);
        chk("R3 idle", irq_o, 0);
    endtask

    task automatic t_levels();
        wr_pri(6'b100000);
        flag_i = 6'b100001;
        wait_cap();
        chk("R7 high wins", vec_o, SRC_TMR2);
        chk("R7 level", lvl_o, 1);
        do_ack();
        flag_i[5] = 1'b0;
        chk("R8 high blocks low", irq_o, 0);
        do_reti();
        chk("R9 back to low vec", vec_o, SRC_EXT0);
        chk("R9 back to low irq", irq_o, 1);
        do_ack();
        flag_i[0] = 1'b0;
        flag_i[5] = 1'b1;
        wait_cap();
        chk("R8 preempt irq", irq_o, 1);
        chk("R8 preempt vec", vec_o, SRC_TMR2);
        do_ack();
        flag_i[5] = 1'b0;
        flag_i[2] = 1'b1;
        wait_cap();
        chk("R8 nested blocks", irq_o, 0);
        do_reti();
        chk("R9 low still active", irq_o, 0);
        do_reti();
        chk("R9 all done irq", irq_o, 1);
        chk("R9 all done vec", vec_o, SRC_EXT1);
        do_ack();
        flag_i[2] = 1'b0;
        do_reti();
        wr_pri(6'b000000);
        wait_cap();
    endtask

    task automatic t_timing();
        wait_state(3'd1);
        flag_i[5] = 1'b1;
        step();
        chk("R5 same cycle capture", irq_o, 1);
        chk("R5 same cycle vec", vec_o, SRC_TMR2);
        do_ack();
        flag_i[5] = 1'b0;
        do_reti();
        wait_state(3'd4);
        flag_i[1] = 1'b1;
        step();
        chk("R5 late flag state5", irq_o, 0);
        step();
        chk("R5 late flag state0", irq_o, 0);
        step();
        chk("R5 late flag state1", irq_o, 0);
        step();
        chk("R5 next cycle irq", irq_o, 1);
        chk("R5 next cycle vec", vec_o, SRC_TMR0);
        do_ack();
        chk("R10 timer0 clear", clr_o, 6'b000010);
        flag_i[1] = 1'b0;
        do_reti();
    endtask

    initial begin
        step(); step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reserved();
        t_order();
        t_enable();
        t_levels();
        t_timing();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule